// File: doc/BRIEF.md
# Split Isochronous IN Completion Tracker

This block tracks the transfer state of one split-transaction isochronous IN descriptor inside a USB 2.0 host controller while complete-split results come back from the hub. A fetch stage loads the descriptor fields: active flag, bytes still expected, buffer offset, page-select bit, complete-split mask and complete-split progress mask. The block then holds these fields and updates them as the schedule commits complete-splits and as result events arrive. The updated fields are presented as registered outputs so that a write-back stage can store them.

For each complete-split it decides whether the transaction may go ahead. At the two scheduling-boundary microframes this decision depends on whether the previous microframe made progress. For each data result it works out the new byte count, offset and page, or it detects babble. Transaction errors are retried up to a fixed limit using a private counter that is never written back. A memory-write enable for the payload and a retry request are issued as one-cycle pulses.

Top module: `sitd_cs_tracker`

## Requirements
- R1: When `cs_commit` is high, the tracker is active, `ld_cmask` bit `uframe[2:0]` is set (as held) and the boundary check of R9 does not block, the next cycle shows `cs_go` high for one cycle and progress-mask bit `uframe[2:0]` set. The retry counter is also cleared.
- R2: A data event that is accepted (kind 0 = MDATA, kind 1 = DATA, babble rules not met) lowers `remain` by `evt_bytes` and advances `offset` by `evt_bytes` modulo 2^OFFW. `wr_en` pulses for one cycle when `evt_bytes` is nonzero.
- R3: If an accepted data event takes `offset + evt_bytes` to 2^OFFW or beyond, `page` becomes 1.
- R4: A data event with `evt_bytes` greater than `remain` causes babble. This includes any nonzero payload when `remain` is zero. On babble `wr_en` stays low, `active` clears, `sts_babble` sets, and `remain`, `offset` and `page` keep their values.
- R5: A data event with `evt_bytes` greater than MAXPAY (192) is babble in the same way as R4, even when `remain` has room for it.
- R6: Event kind 3 (ERR) sets `sts_err` and clears `active`.
- R7: Event kind 2 (transaction error) sets `sts_xact`. While fewer than MAXRETRY (2) retries have been granted since the last commit or non-error result, `retry_req` pulses for one cycle. Once the limit is reached, a further transaction error clears `active` and gives no retry.
- R8: `eom` clears `active` while a transaction error is still outstanding, that is, while the retry counter is nonzero.
- R9: When `uframe[2:0]` is 0 or 1 and progress-mask bit `(uframe[2:0]-1) mod 8` is clear, a commit whose mask bit is set pulses `cs_skip` and leaves the progress mask unchanged.
- R10: An accepted DATA event (kind 1) clears `active`. An accepted MDATA event (kind 0) leaves `active` set.
- R11: Any event of kind 0, 1 or 3 clears the retry counter.
- R12: While `active` is low, events, commits and `eom` change no field and produce no pulse.
- R13: `ld_valid` takes priority over all other inputs in the same cycle. It loads the fields, clears the status bits and clears the retry counter. The order of priority below it is event, then commit, then `eom`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load descriptor fields |
| ld_active | input | 1 | Active flag to load |
| ld_remain | input | REMW | Bytes still expected |
| ld_offset | input | OFFW | Buffer offset within page |
| ld_page | input | 1 | Page-select bit |
| ld_cmask | input | 8 | Complete-split mask |
| ld_cprog | input | 8 | Complete-split progress mask |
| uframe | input | UFW | Microframe index |
| cs_commit | input | 1 | Schedule commits a complete-split |
| eom | input | 1 | End-of-microframe strobe |
| evt_valid | input | 1 | Result event present |
| evt_kind | input | 2 | 0 MDATA, 1 DATA, 2 transaction error, 3 ERR |
| evt_bytes | input | CNTW | Payload byte count |
| active | output | 1 | Active flag |
| remain | output | REMW | Bytes still expected |
| offset | output | OFFW | Current offset |
| page | output | 1 | Page-select bit |
| cprog | output | 8 | Progress mask |
| sts_babble | output | 1 | Babble status |
| sts_err | output | 1 | ERR status |
| sts_xact | output | 1 | Transaction-error status |
| wr_en | output | 1 | Payload memory-write enable pulse |
| retry_req | output | 1 | Immediate retry request pulse |
| cs_go | output | 1 | Complete-split performed |
| cs_skip | output | 1 | Complete-split refused at boundary |

## Verification
Several properties are checked by assertions on every cycle:
- the retry counter never passes its limit;
- a retry request only ever comes with an active descriptor whose transaction-error bit is set;
- go and skip never pulse together;
- babble never coincides with a memory write;
- without a load, the progress mask never loses a bit and the byte count never grows.

Other behaviour can only be shown by the bench's scenarios, where a behavioural model is compared against the outputs on every clock:
- the arithmetic of offset and page crossing;
- which microframe bit is tested at the boundaries;
- the count of three consecutive errors;
- the interaction of `eom` with an outstanding error.

// File: rtl/sitd_pkg.sv
package sitd_pkg;
  localparam int NUF = 8;
  typedef enum logic [1:0] {
    EV_MDATA = 2'd0,
    EV_DATA  = 2'd1,
    EV_XERR  = 2'd2,
    EV_ERR   = 2'd3
  } sitd_evt_e;
endpackage

// File: rtl/sitd_boundary_chk.sv
module sitd_boundary_chk
  import sitd_pkg::*;
(
  input  logic [2:0]     uf,
  input  logic [NUF-1:0] cmask,
  input  logic [NUF-1:0] cprog,
  output logic           go,
  output logic           skip
);
  logic [2:0] prev_uf;
  logic       edge_uf;
  logic       prev_done;

  always_comb begin
    prev_uf   = uf - 3'd1;
    edge_uf   = (uf == 3'd0) || (uf == 3'd1);
    prev_done = cprog[prev_uf];
    go        = cmask[uf] && (!edge_uf || prev_done);
    skip      = cmask[uf] && edge_uf && !prev_done;
  end
endmodule

// File: rtl/sitd_xfer_calc.sv
module sitd_xfer_calc #(
  parameter int REMW   = 10,
  parameter int OFFW   = 12,
  parameter int CNTW   = 9,
  parameter int MAXPAY = 192
) (
  input  logic [REMW-1:0] remain,
  input  logic [OFFW-1:0] offset,
  input  logic            page,
  input  logic [CNTW-1:0] bytes,
  output logic            babble,
  output logic [REMW-1:0] nremain,
  output logic [OFFW-1:0] noffset,
  output logic            npage
);
  localparam int WW = ((REMW > CNTW) ? REMW : CNTW) + 1;
  logic [WW-1:0]   b_ext;
  logic [WW-1:0]   r_ext;
  logic [WW-1:0]   diff;
  logic [OFFW:0]   sum;

  always_comb begin
    b_ext   = WW'(bytes);
    r_ext   = WW'(remain);
    babble  = (b_ext > r_ext) || (b_ext > WW'(MAXPAY));
    diff    = r_ext - b_ext;
    nremain = diff[REMW-1:0];
    sum     = (OFFW+1)'(offset) + (OFFW+1)'(bytes);
    noffset = sum[OFFW-1:0];
    npage   = page | sum[OFFW];
  end
endmodule

// File: rtl/sitd_retry_ctr.sv
module sitd_retry_ctr #(
  parameter int MAXRETRY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic pending,
  output logic spent
);
  localparam int CW = $clog2(MAXRETRY + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)      cnt_q <= '0;
    else if (inc && !spent) cnt_q <= cnt_q + CW'(1);
  end

  assign pending = (cnt_q != '0);
  assign spent   = (cnt_q == CW'(MAXRETRY));

  // R7
  retry_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(MAXRETRY));
endmodule

// File: rtl/sitd_cs_tracker.sv
module sitd_cs_tracker
  import sitd_pkg::*;
#(
  parameter int REMW     = 10,
  parameter int OFFW     = 12,
  parameter int CNTW     = 9,
  parameter int UFW      = 14,
  parameter int MAXPAY   = 192,
  parameter int MAXRETRY = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_valid,
  input  logic            ld_active,
  input  logic [REMW-1:0] ld_remain,
  input  logic [OFFW-1:0] ld_offset,
  input  logic            ld_page,
  input  logic [7:0]      ld_cmask,
  input  logic [7:0]      ld_cprog,
  input  logic [UFW-1:0]  uframe,
  input  logic            cs_commit,
  input  logic            eom,
  input  logic            evt_valid,
  input  logic [1:0]      evt_kind,
  input  logic [CNTW-1:0] evt_bytes,
  output logic            active,
  output logic [REMW-1:0] remain,
  output logic [OFFW-1:0] offset,
  output logic            page,
  output logic [7:0]      cprog,
  output logic            sts_babble,
  output logic            sts_err,
  output logic            sts_xact,
  output logic            wr_en,
  output logic            retry_req,
  output logic            cs_go,
  output logic            cs_skip
);
  logic [NUF-1:0] cmask_q;
  logic           bnd_go, bnd_skip;
  logic           x_babble, x_page;
  logic [REMW-1:0] x_remain;
  logic [OFFW-1:0] x_offset;
  logic           rc_pending, rc_spent, rc_clr, rc_inc;
  logic           evt_live, is_data;
  sitd_evt_e      kind;

  sitd_boundary_chk u_bnd (
    .uf(uframe[2:0]), .cmask(cmask_q), .cprog(cprog),
    .go(bnd_go), .skip(bnd_skip)
  );

  sitd_xfer_calc #(.REMW(REMW), .OFFW(OFFW), .CNTW(CNTW), .MAXPAY(MAXPAY)) u_calc (
    .remain(remain), .offset(offset), .page(page), .bytes(evt_bytes),
    .babble(x_babble), .nremain(x_remain), .noffset(x_offset), .npage(x_page)
  );

  sitd_retry_ctr #(.MAXRETRY(MAXRETRY)) u_rc (
    .clk(clk), .rst(rst), .clr(rc_clr), .inc(rc_inc),
    .pending(rc_pending), .spent(rc_spent)
  );

  always_comb begin
    kind     = sitd_evt_e'(evt_kind);
    evt_live = !ld_valid && evt_valid && active;
    is_data  = (kind == EV_MDATA) || (kind == EV_DATA);
    rc_clr   = ld_valid
             || (evt_live && kind != EV_XERR)
             || (!ld_valid && !evt_valid && cs_commit && active && bnd_go);
    rc_inc   = evt_live && kind == EV_XERR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; remain <= '0; offset <= '0; page <= 1'b0;
      cprog <= '0; cmask_q <= '0;
      sts_babble <= 1'b0; sts_err <= 1'b0; sts_xact <= 1'b0;
      wr_en <= 1'b0; retry_req <= 1'b0; cs_go <= 1'b0; cs_skip <= 1'b0;
    end else begin
      wr_en <= 1'b0; retry_req <= 1'b0; cs_go <= 1'b0; cs_skip <= 1'b0;
      if (ld_valid) begin
        active <= ld_active; remain <= ld_remain; offset <= ld_offset;
        page <= ld_page; cmask_q <= ld_cmask; cprog <= ld_cprog;
        sts_babble <= 1'b0; sts_err <= 1'b0; sts_xact <= 1'b0;
      end else if (evt_valid) begin
        if (active) begin
          if (is_data) begin
            if (x_babble) begin
              active <= 1'b0; sts_babble <= 1'b0 | 1'b1;
            end else begin
              remain <= x_remain; offset <= x_offset; page <= x_page;
              wr_en  <= (evt_bytes != '0);
              if (kind == EV_DATA) active <= 1'b0;
            end
          end else if (kind == EV_ERR) begin
            sts_err <= 1'b1; active <= 1'b0;
          end else begin
            sts_xact <= 1'b1;
            if (rc_spent) active <= 1'b0;
            else          retry_req <= 1'b1;
          end
        end
      end else if (cs_commit) begin
        if (active) begin
          if (bnd_go) begin
            cprog <= cprog | (NUF'(1) << uframe[2:0]);
            cs_go <= 1'b1;
          end
          cs_skip <= bnd_skip;
        end
      end else if (eom) begin
        if (active && rc_pending) active <= 1'b0;
      end
    end
  end

  // R7
  retry_ctx_chk: assert property (@(posedge clk) disable iff (rst)
    retry_req |-> (active && sts_xact));
  // R9
  go_skip_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cs_go && cs_skip));
  // R4
  babble_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_babble) |-> !wr_en);
  // R1
  cprog_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> ((cprog & $past(cprog)) == $past(cprog)));
  // R2
  remain_down_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> (remain <= $past(remain)));
endmodule

// File: tb/test_sitd_cs_tracker.sv
module test_sitd_cs_tracker;
  localparam int REMW = 10, OFFW = 12, CNTW = 9, UFW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_valid = 0, ld_active = 0, ld_page = 0;
  logic [REMW-1:0] ld_remain = '0;
  logic [OFFW-1:0] ld_offset = '0;
  logic [7:0] ld_cmask = '0, ld_cprog = '0;
  logic [UFW-1:0] uframe = '0;
  logic cs_commit = 0, eom = 0, evt_valid = 0;
  logic [1:0] evt_kind = '0;
  logic [CNTW-1:0] evt_bytes = '0;
  logic active, page, sts_babble, sts_err, sts_xact, wr_en, retry_req, cs_go, cs_skip;
  logic [REMW-1:0] remain;
  logic [OFFW-1:0] offset;
  logic [7:0] cprog;

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  sitd_cs_tracker i_sitd_cs_tracker (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_active(ld_active),
    .ld_remain(ld_remain), .ld_offset(ld_offset), .ld_page(ld_page),
    .ld_cmask(ld_cmask), .ld_cprog(ld_cprog), .uframe(uframe),
    .cs_commit(cs_commit), .eom(eom), .evt_valid(evt_valid),
    .evt_kind(evt_kind), .evt_bytes(evt_bytes), .active(active),
    .remain(remain), .offset(offset), .page(page), .cprog(cprog),
    .sts_babble(sts_babble), .sts_err(sts_err), .sts_xact(sts_xact),
    .wr_en(wr_en), .retry_req(retry_req), .cs_go(cs_go), .cs_skip(cs_skip)
  );

  // behavioural reference
  int m_act, m_rem, m_off, m_pg, m_cm, m_cp, m_bab, m_err, m_xa;
  int m_wr, m_rt, m_go, m_sk, m_rc;

  always @(posedge clk) begin
    int u, pv, b;
    bit edge_uf, prev_ok;
    m_wr = 0; m_rt = 0; m_go = 0; m_sk = 0;
    if (rst) begin
      m_act = 0; m_rem = 0; m_off = 0; m_pg = 0; m_cm = 0; m_cp = 0;
      m_bab = 0; m_err = 0; m_xa = 0; m_rc = 0;
    end else if (ld_valid) begin
      m_act = ld_active; m_rem = ld_remain; m_off = ld_offset; m_pg = ld_page;
      m_cm = ld_cmask; m_cp = ld_cprog; m_bab = 0; m_err = 0; m_xa = 0; m_rc = 0;
    end else if (evt_valid) begin
      if (m_act != 0) begin
        b = evt_bytes;
        if (evt_kind == 2) begin
          m_xa = 1;
          if (m_rc >= 2) m_act = 0;
          else begin m_rc++; m_rt = 1; end
        end else begin
          m_rc = 0;
          if (evt_kind == 3) begin m_err = 1; m_act = 0; end
          else if (b > m_rem || b > 192) begin m_bab = 1; m_act = 0; end
          else begin
            m_rem -= b; m_off += b;
            if (m_off >= 4096) begin m_off -= 4096; m_pg = 1; end
            m_wr = (b != 0);
            if (evt_kind == 1) m_act = 0;
          end
        end
      end
    end else if (cs_commit) begin
      if (m_act != 0) begin
        u = uframe % 8; pv = (u + 7) % 8;
        edge_uf = (u < 2); prev_ok = ((m_cp >> pv) & 1) != 0;
        if (((m_cm >> u) & 1) != 0) begin
          if (!edge_uf || prev_ok) begin m_cp |= (1 << u); m_go = 1; m_rc = 0; end
          else m_sk = 1;
        end
      end
    end else if (eom) begin
      if (m_act != 0 && m_rc != 0) m_act = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R8 active", active, m_act);
    chk("R2 remain", remain, m_rem);
    chk("R2 offset", offset, m_off);
    chk("R3 page", page, m_pg);
    chk("R1 cprog", cprog, m_cp);
    chk("R4 babble", sts_babble, m_bab);
    chk("R6 err", sts_err, m_err);
    chk("R7 xact", sts_xact, m_xa);
    chk("R5 wr_en", wr_en, m_wr);
    chk("R11 retry", retry_req, m_rt);
    chk("R1 go", cs_go, m_go);
    chk("R9 skip", cs_skip, m_sk);
  end

  task automatic load(int act, int rem, int off, int cm, int cp);
    @(negedge clk);
    ld_valid = 1; ld_active = act[0]; ld_remain = REMW'(rem);
    ld_offset = OFFW'(off); ld_page = 0; ld_cmask = 8'(cm); ld_cprog = 8'(cp);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic ev(int k, int b);
    @(negedge clk);
    evt_valid = 1; evt_kind = 2'(k); evt_bytes = CNTW'(b);
    @(negedge clk);
    evt_valid = 0;
  endtask

  task automatic commit(int uf);
    @(negedge clk);
    cs_commit = 1; uframe = UFW'(uf);
    @(negedge clk);
    cs_commit = 0;
  endtask

  task automatic end_uf();
    @(negedge clk);
    eom = 1;
    @(negedge clk);
    eom = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R13 reset active", active, 0);
    chk("R13 reset remain", remain, 0);
    cmp_on = 1;
    // main path, page crossing
    load(1, 500, 4000, 8'h1C, 8'h00);
    commit(2);
    ev(0, 150);
    chk("R3 page crossed", page, 1);
    chk("R10 mdata keeps active", active, 1);
    commit(3);
    ev(2, 0); ev(2, 0); ev(2, 0);
    chk("R7 third error clears", active, 0);
    // eom with outstanding error
    load(1, 300, 0, 8'h1C, 8'h00);
    commit(4); ev(2, 0); end_uf();
    chk("R8 eom clears", active, 0);
    // non-error result clears counter
    load(1, 300, 0, 8'h1C, 8'h00);
    commit(2); ev(2, 0); ev(0, 10); ev(2, 0); ev(2, 0);
    chk("R11 still active", active, 1);
    ev(2, 0);
    // babble cases
    load(1, 100, 0, 8'h1C, 8'h00); ev(0, 200);
    chk("R4 babble over remain", sts_babble, 1);
    load(1, 300, 0, 8'h1C, 8'h00); ev(0, 193);
    chk("R5 babble over max", sts_babble, 1);
    load(1, 300, 0, 8'h1C, 8'h00); ev(0, 192);
    chk("R5 max accepted", remain, 108);
    load(1, 0, 40, 8'h1C, 8'h00); ev(1, 5);
    chk("R4 zero remain offset kept", offset, 40);
    load(1, 0, 40, 8'h1C, 8'h00); ev(1, 0);
    chk("R10 data zero ok", sts_babble, 0);
    // ERR
    load(1, 100, 0, 8'h1C, 8'h00); ev(3, 0);
    chk("R6 err set", sts_err, 1);
    // inactive ignores everything
    ev(0, 10); commit(2); end_uf();
    chk("R12 remain kept", remain, 100);
    chk("R12 cprog kept", cprog, 0);
    // boundary microframes
    load(1, 100, 0, 8'h03, 8'h00); commit(0);
    chk("R9 skip uf0", cprog, 0);
    load(1, 100, 0, 8'h03, 8'h80); commit(0); commit(1);
    chk("R9 pass uf0 and uf1", cprog, 8'h83);
    load(1, 100, 0, 8'h02, 8'h00); commit(9);
    chk("R9 skip uf9", cprog, 0);
    load(1, 100, 0, 8'h02, 8'h00); commit(3);
    chk("R1 mask clear no go", cprog, 0);
    // DATA final
    load(1, 100, 0, 8'h1C, 8'h00); ev(1, 20);
    chk("R10 data clears", active, 0);
    chk("R2 data remain", remain, 80);
    // load wins over event in same cycle
    @(negedge clk);
    ld_valid = 1; ld_active = 1; ld_remain = 10'd77; ld_offset = '0;
    ld_cmask = 8'h1C; ld_cprog = 8'h00; evt_valid = 1; evt_kind = 2'd1; evt_bytes = 9'd5;
    @(negedge clk);
    ld_valid = 0; evt_valid = 0;
    chk("R13 load priority", remain, 77);
    repeat (2) @(negedge clk);
    cmp_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule